// File: doc/BRIEF.md
# Parallel Link Sampling-Offset Calibrator

This block picks the receive sampling offset for a parallel word link whose data lines carry no clock of their own. On a start request it steps a candidate offset through a programmable range of clock counts. For every candidate it presents the offset to the link, fires a trigger, and streams a fixed-length burst of pseudo-random test words into the link. The words that come back are compared, in order, against a locally regenerated copy of the same sequence.

A candidate counts as good only when every word of its burst returns intact. The block keeps the widest contiguous run of good candidates as the passing window. At the end of the sweep it drives the midpoint of that window onto the offset output, so that the chosen point sits as far as possible from both failing edges. If no candidate is good it raises a fail flag and returns the offset to its reset value. The result stays on the outputs until the next start.

The test words come from a 32-bit LFSR restarted from the same seed for every candidate. Every word therefore differs from the word before it, and a receiver sampling one word early or late cannot produce a false match.

Top module: `lnk_skew_cal`

## Requirements
- R1: After reset `tap_o` equals RST_OFS (default 0). `cal_busy_o`, `cal_done_o` and `cal_fail_o` are 0, and `sel_ofs_o`, `win_lo_o` and `win_hi_o` are 0.
- R2: A start accepted while idle tests offsets `sweep_lo_i`, `sweep_lo_i`+1, ... up to `sweep_hi_i` in ascending order. `tap_o` holds the candidate while its burst runs, and each candidate gets exactly one `burst_go_o` pulse. If `sweep_hi_i` < `sweep_lo_i`, only `sweep_lo_i` is tested.
- R3: A burst begins the cycle after `burst_go_o` and places BURST_LEN (16) words on `tx_word_o` in consecutive cycles with `tx_vld_o` high. The first word is the seed 32'hACE1_2B3F. Each later word is the previous word shifted left by one, XORed with 32'h0040_0007 when the previous word's bit 31 was 1. Consecutive words always differ.
- R4: A candidate passes only when the first BURST_LEN words received after its trigger all equal the expected words in order. Received words beyond BURST_LEN, and words that arrive while no sweep runs, have no effect.
- R5: A candidate fails when its BURST_LEN words have not all arrived within TMO_CYC (64) cycles, and the sweep then moves on.
- R6: The window is the widest contiguous run of passing offsets. When runs are equally wide, the run with the lowest offsets is kept. `win_lo_o` and `win_hi_o` report the run's first and last offsets.
- R7: The chosen offset is floor((win_lo + win_hi)/2). After the sweep it appears on both `sel_ofs_o` and `tap_o`.
- R8: If no offset passes, `cal_fail_o` is set, `tap_o` returns to RST_OFS, and `sel_ofs_o`, `win_lo_o` and `win_hi_o` are 0.
- R9: `cal_done_o` pulses for exactly one cycle when the sweep ends. The results and `tap_o` then hold steady until the next start. An accepted start clears the results and sets `cal_busy_o`.
- R10: A start request while `cal_busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_start_i | input | 1 | Request a calibration sweep |
| sweep_lo_i | input | OFS_W | First offset of the sweep |
| sweep_hi_i | input | OFS_W | Last offset of the sweep |
| tap_o | output | OFS_W | Sampling offset applied by the link |
| burst_go_o | output | 1 | One-cycle trigger for a test burst |
| tx_vld_o | output | 1 | Test word valid toward the link |
| tx_word_o | output | 32 | Test word toward the link |
| rx_vld_i | input | 1 | Received word valid from the link |
| rx_word_i | input | 32 | Received word from the link |
| cal_busy_o | output | 1 | Sweep in progress |
| cal_done_o | output | 1 | One-cycle pulse at the end of the sweep |
| cal_fail_o | output | 1 | No offset passed |
| sel_ofs_o | output | OFS_W | Chosen offset (window midpoint) |
| win_lo_o | output | OFS_W | First offset of the passing window |
| win_hi_o | output | OFS_W | Last offset of the passing window |

## Verification
The assertions assume that `sweep_lo_i` and `sweep_hi_i` hold steady while a start is presented. They also assume that the link returns no more than one received word per cycle and only words belonging to the most recent trigger, so stale words from an earlier candidate never reach a later one.

The bench link model meets these assumptions. It delays each transmitted word by a fixed three cycles and returns either that word or its predecessor, depending on whether the candidate lies inside the modelled good range. For chosen offsets it can instead stay silent, corrupt a single word, or append one surplus word. Stray words are injected only while the block is idle.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  localparam word_t LFSR_MASK = 32'h0040_0007;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ARM  = 3'd1,
    ST_RUN  = 3'd2,
    ST_EVAL = 3'd3,
    ST_FIN  = 3'd4
  } seq_st_e;

  // Galois LFSR step, polynomial x^32 + x^22 + x^2 + x + 1
  function automatic word_t lfsr_step(input word_t cur);
    word_t nxt;
    nxt = {cur[WORD_W-2:0], 1'b0};
    if (cur[WORD_W-1]) nxt = nxt ^ LFSR_MASK;
    return nxt;
  endfunction

endpackage

// File: rtl/lsc_pat_gen.sv
module lsc_pat_gen
  import lsc_pkg::*;
#(
  parameter int    BURST_LEN = 16,
  parameter word_t SEED      = 32'hACE1_2B3F
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  go_i,
  output logic  vld_o,
  output word_t word_o
);
  localparam int CW = $clog2(BURST_LEN + 1);
  localparam logic [CW-1:0] FULL = CW'(BURST_LEN);

  logic [CW-1:0] left_q;
  word_t         word_q;
  logic          emit;

  assign emit   = (left_q != '0);
  assign vld_o  = emit;
  assign word_o = word_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= '0;
      word_q <= '0;
    end else if (go_i) begin
      left_q <= FULL;
      word_q <= SEED;
    end else if (emit) begin
      left_q <= left_q - 1'b1;
      word_q <= lfsr_step(word_q);
    end
  end

  // R3
  word_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && $past(vld_o) && !$past(go_i)) |-> (word_o != $past(word_o)));

  // R3
  seed_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |=> (vld_o && word_o == SEED));

endmodule

// File: rtl/lsc_rx_check.sv
module lsc_rx_check
  import lsc_pkg::*;
#(
  parameter int    BURST_LEN = 16,
  parameter word_t SEED      = 32'hACE1_2B3F
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  arm_i,
  input  logic  rx_vld_i,
  input  word_t rx_word_i,
  output logic  done_o,
  output logic  pass_o
);
  localparam int CW = $clog2(BURST_LEN + 1);
  localparam logic [CW-1:0] FULL = CW'(BURST_LEN);

  word_t         exp_q;
  logic [CW-1:0] rcv_q;
  logic [CW-1:0] hit_q;
  logic          take;
  logic          word_hit;

  assign take     = rx_vld_i && (rcv_q != FULL);
  assign word_hit = take && (rx_word_i == exp_q);
  assign done_o   = (rcv_q == FULL);
  assign pass_o   = (hit_q == FULL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_q <= '0;
      rcv_q <= FULL;
      hit_q <= '0;
    end else if (arm_i) begin
      exp_q <= SEED;
      rcv_q <= '0;
      hit_q <= '0;
    end else if (take) begin
      exp_q <= lfsr_step(exp_q);
      rcv_q <= rcv_q + 1'b1;
      if (word_hit) hit_q <= hit_q + 1'b1;
    end
  end

  // R4
  hit_le_rcv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(arm_i) && $past(rcv_q) == FULL && $past(hit_q) == '0) |-> (hit_q == '0));

  // R4
  no_take_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !arm_i) |=> ($stable(hit_q) && $stable(rcv_q)));

  // R4
  pass_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_o |-> done_o);

endmodule

// File: rtl/lsc_win_track.sv
module lsc_win_track #(
  parameter int OFS_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             upd_i,
  input  logic             pass_i,
  input  logic [OFS_W-1:0] tap_i,
  output logic             have_o,
  output logic [OFS_W-1:0] lo_o,
  output logic [OFS_W-1:0] hi_o
);
  localparam logic [OFS_W:0] ONE = {{OFS_W{1'b0}}, 1'b1};

  logic             in_run_q;
  logic [OFS_W-1:0] run_lo_q;
  logic [OFS_W:0]   best_len_q;
  logic [OFS_W-1:0] cand_lo;
  logic [OFS_W:0]   cand_len;
  logic             widen;

  assign cand_lo  = in_run_q ? run_lo_q : tap_i;
  assign cand_len = {1'b0, tap_i} - {1'b0, cand_lo} + ONE;
  assign widen    = upd_i && pass_i && (cand_len > best_len_q);

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      in_run_q   <= 1'b0;
      run_lo_q   <= '0;
      best_len_q <= '0;
      have_o     <= 1'b0;
      lo_o       <= '0;
      hi_o       <= '0;
    end else if (upd_i) begin
      if (pass_i) begin
        in_run_q <= 1'b1;
        run_lo_q <= cand_lo;
        if (widen) begin
          best_len_q <= cand_len;
          lo_o       <= cand_lo;
          hi_o       <= tap_i;
          have_o     <= 1'b1;
        end
      end else begin
        in_run_q <= 1'b0;
      end
    end
  end

  // R6
  win_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    have_o |-> (lo_o <= hi_o));

  // R6
  fail_breaks_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && !pass_i && !clr_i) |=> !in_run_q);

endmodule

// File: rtl/lsc_sweep_seq.sv
module lsc_sweep_seq
  import lsc_pkg::*;
#(
  parameter int OFS_W   = 5,
  parameter int TMO_CYC = 64,
  parameter int RST_OFS = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [OFS_W-1:0] lo_i,
  input  logic [OFS_W-1:0] hi_i,
  input  logic             chk_done_i,
  input  logic             chk_pass_i,
  input  logic             have_i,
  input  logic [OFS_W-1:0] best_lo_i,
  input  logic [OFS_W-1:0] best_hi_i,
  output logic [OFS_W-1:0] tap_o,
  output logic             go_o,
  output logic             trk_clr_o,
  output logic             trk_upd_o,
  output logic             trk_pass_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             fail_o,
  output logic [OFS_W-1:0] sel_o,
  output logic [OFS_W-1:0] wlo_o,
  output logic [OFS_W-1:0] whi_o
);
  localparam int TW = $clog2(TMO_CYC + 1);
  localparam logic [TW-1:0]    TMO_LAST = TW'(TMO_CYC - 1);
  localparam logic [OFS_W-1:0] OFS_RST  = OFS_W'(RST_OFS);
  localparam logic [OFS_W-1:0] OFS_ONE  = {{(OFS_W-1){1'b0}}, 1'b1};

  function automatic logic [OFS_W-1:0] mid_of(input logic [OFS_W-1:0] a,
                                              input logic [OFS_W-1:0] b);
    logic [OFS_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[OFS_W:1];
  endfunction

  seq_st_e          st_q;
  logic [TW-1:0]    tmo_q;
  logic [OFS_W-1:0] lo_q;
  logic [OFS_W-1:0] hi_q;

  logic start_acc;
  logic tmo_hit;
  logic step_end;
  logic sweep_last;

  assign start_acc  = (st_q == ST_IDLE) && start_i;
  assign tmo_hit    = (st_q == ST_RUN) && (tmo_q == TMO_LAST);
  assign step_end   = (st_q == ST_RUN) && (chk_done_i || tmo_hit);
  assign sweep_last = (tap_o >= hi_q);

  assign go_o       = (st_q == ST_ARM);
  assign busy_o     = (st_q != ST_IDLE);
  assign trk_clr_o  = start_acc;
  assign trk_upd_o  = (st_q == ST_EVAL);
  assign trk_pass_o = chk_pass_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      tmo_q  <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      tap_o  <= OFS_RST;
      done_o <= 1'b0;
      fail_o <= 1'b0;
      sel_o  <= '0;
      wlo_o  <= '0;
      whi_o  <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_acc) begin
            lo_q   <= lo_i;
            hi_q   <= hi_i;
            tap_o  <= lo_i;
            fail_o <= 1'b0;
            sel_o  <= '0;
            wlo_o  <= '0;
            whi_o  <= '0;
            st_q   <= ST_ARM;
          end
        end
        ST_ARM: begin
          tmo_q <= '0;
          st_q  <= ST_RUN;
        end
        ST_RUN: begin
          tmo_q <= tmo_q + 1'b1;
          if (step_end) st_q <= ST_EVAL;
        end
        ST_EVAL: begin
          if (sweep_last) begin
            st_q <= ST_FIN;
          end else begin
            tap_o <= tap_o + OFS_ONE;
            st_q  <= ST_ARM;
          end
        end
        ST_FIN: begin
          done_o <= 1'b1;
          if (have_i) begin
            tap_o <= mid_of(best_lo_i, best_hi_i);
            sel_o <= mid_of(best_lo_i, best_hi_i);
            wlo_o <= best_lo_i;
            whi_o <= best_hi_i;
          end else begin
            fail_o <= 1'b1;
            tap_o  <= OFS_RST;
          end
          st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  tap_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ARM || st_q == ST_RUN || st_q == ST_EVAL)
      |-> (tap_o >= lo_q && (tap_o <= hi_q || tap_o == lo_q)));

  // R2
  tap_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN) |=> $stable(tap_o));

  // R5
  tmo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> (st_q == ST_EVAL));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  sel_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !fail_o) |-> (wlo_o <= sel_o && sel_o <= whi_o && tap_o == sel_o));

  // R8
  fail_reset_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && fail_o) |-> (tap_o == OFS_RST && sel_o == '0 && wlo_o == '0 && whi_o == '0));

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !start_i)
      |=> ($stable(tap_o) && $stable(sel_o) && $stable(fail_o) && $stable(wlo_o) && $stable(whi_o)));

  // R10
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ($stable(lo_q) && $stable(hi_q)));

endmodule

// File: rtl/lnk_skew_cal.sv
module lnk_skew_cal
  import lsc_pkg::*;
#(
  parameter int    OFS_W     = 5,
  parameter int    BURST_LEN = 16,
  parameter int    TMO_CYC   = 64,
  parameter int    RST_OFS   = 0,
  parameter word_t SEED      = 32'hACE1_2B3F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_start_i,
  input  logic [OFS_W-1:0]  sweep_lo_i,
  input  logic [OFS_W-1:0]  sweep_hi_i,
  output logic [OFS_W-1:0]  tap_o,
  output logic              burst_go_o,
  output logic              tx_vld_o,
  output logic [WORD_W-1:0] tx_word_o,
  input  logic              rx_vld_i,
  input  logic [WORD_W-1:0] rx_word_i,
  output logic              cal_busy_o,
  output logic              cal_done_o,
  output logic              cal_fail_o,
  output logic [OFS_W-1:0]  sel_ofs_o,
  output logic [OFS_W-1:0]  win_lo_o,
  output logic [OFS_W-1:0]  win_hi_o
);
  logic             chk_done;
  logic             chk_pass;
  logic             trk_clr;
  logic             trk_upd;
  logic             trk_pass;
  logic             trk_have;
  logic [OFS_W-1:0] trk_lo;
  logic [OFS_W-1:0] trk_hi;
  logic [OFS_W-1:0] trk_tap;

  assign trk_tap = tap_o;

  lsc_sweep_seq #(
    .OFS_W(OFS_W), .TMO_CYC(TMO_CYC), .RST_OFS(RST_OFS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(cal_start_i),
    .lo_i(sweep_lo_i), .hi_i(sweep_hi_i),
    .chk_done_i(chk_done), .chk_pass_i(chk_pass),
    .have_i(trk_have), .best_lo_i(trk_lo), .best_hi_i(trk_hi),
    .tap_o(tap_o), .go_o(burst_go_o),
    .trk_clr_o(trk_clr), .trk_upd_o(trk_upd), .trk_pass_o(trk_pass),
    .busy_o(cal_busy_o), .done_o(cal_done_o), .fail_o(cal_fail_o),
    .sel_o(sel_ofs_o), .wlo_o(win_lo_o), .whi_o(win_hi_o)
  );

  lsc_pat_gen #(.BURST_LEN(BURST_LEN), .SEED(SEED)) u_gen (
    .clk(clk), .rst_n(rst_n), .go_i(burst_go_o),
    .vld_o(tx_vld_o), .word_o(tx_word_o)
  );

  lsc_rx_check #(.BURST_LEN(BURST_LEN), .SEED(SEED)) u_chk (
    .clk(clk), .rst_n(rst_n), .arm_i(burst_go_o),
    .rx_vld_i(rx_vld_i), .rx_word_i(rx_word_i),
    .done_o(chk_done), .pass_o(chk_pass)
  );

  lsc_win_track #(.OFS_W(OFS_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .clr_i(trk_clr), .upd_i(trk_upd),
    .pass_i(trk_pass), .tap_i(trk_tap),
    .have_o(trk_have), .lo_o(trk_lo), .hi_o(trk_hi)
  );

  // R3
  go_starts_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_go_o |=> tx_vld_o);

  // R2
  go_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_go_o |-> (cal_busy_o && !cal_done_o));

endmodule

// File: tb/lnk_skew_cal_bench.sv
`timescale 1ns/1ps
module lnk_skew_cal_bench;
  localparam int OFS_W = 5;
  localparam int BLEN  = 16;
  localparam logic [31:0] SEED_W = 32'hACE1_2B3F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cal_start_i = 1'b0;
  logic [OFS_W-1:0] sweep_lo_i = '0, sweep_hi_i = '0;
  logic [OFS_W-1:0] tap_o, sel_ofs_o, win_lo_o, win_hi_o;
  logic burst_go_o, tx_vld_o, cal_busy_o, cal_done_o, cal_fail_o;
  logic [31:0] tx_word_o;
  logic rx_vld_i = 1'b0;
  logic [31:0] rx_word_i = '0;

  always #2 clk = ~clk;

  lnk_skew_cal u_lnk_skew_cal (.*);

  int checks = 0, errors = 0;

  // link model settings
  logic [31:0] good_m = '0, silent_m = '0, flaky_m = '0;
  bit extra_en = 0;
  int junk_n = 0;

  // reference model state
  int m_next_tap, m_bursts, m_idx;
  logic [31:0] m_lfsr, m_prev_tx;
  bit m_hold = 0;
  logic [OFS_W-1:0] h_tap, h_sel, h_lo, h_hi;
  logic h_fail;
  logic [32:0] p_vld [3];
  bit pend_extra = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_next(input logic [31:0] w);
    return (w << 1) ^ ({32{w[31]}} & 32'h0040_0007);
  endfunction

  initial for (int i = 0; i < 3; i++) p_vld[i] = '0;

  // per-clock reference compare and link model
  always @(negedge clk) begin
    logic [32:0] ent;
    if (rst_n) begin
      if (burst_go_o) begin
        chk(tap_o == m_next_tap[OFS_W-1:0], "R2", "burst offset", tap_o, m_next_tap);
        m_next_tap++; m_bursts++;
        m_lfsr = SEED_W; m_idx = 0; m_prev_tx = '0;
      end
      if (m_hold && !cal_busy_o) begin
        chk(tap_o == h_tap && sel_ofs_o == h_sel && win_lo_o == h_lo &&
            win_hi_o == h_hi && cal_fail_o == h_fail, "R9", "result hold",
            {tap_o, sel_ofs_o}, {h_tap, h_sel});
      end
      ent = '0;
      if (tx_vld_o) begin
        chk(tx_word_o == m_lfsr, "R3", "tx word", tx_word_o, m_lfsr);
        if (!silent_m[tap_o]) begin
          ent[32] = 1'b1;
          ent[31:0] = good_m[tap_o] ? tx_word_o : m_prev_tx;
          if (flaky_m[tap_o] && m_idx == BLEN - 1) ent[31:0] = ent[31:0] ^ 32'h1;
          if (extra_en && m_idx == BLEN - 1) pend_extra = 1;
        end
        m_prev_tx = tx_word_o;
        m_lfsr = ref_next(m_lfsr);
        m_idx++;
      end else if (pend_extra) begin
        ent = {1'b1, 32'hDEAD_BEEF};
        pend_extra = 0;
      end else if (junk_n > 0) begin
        ent = {1'b1, 32'h1234_0000 | 32'(junk_n)};
        junk_n--;
      end
      rx_vld_i  = p_vld[2][32];
      rx_word_i = p_vld[2][31:0];
      p_vld[2] = p_vld[1]; p_vld[1] = p_vld[0]; p_vld[0] = ent;
    end
  end

  task automatic run_cal(input int lo, input int hi, input bit mid_start);
    int last, cur, cur_lo, best, blo, bhi, wait_n, ntaps;
    bit exp_fail;
    int exp_sel;
    last = (hi < lo) ? lo : hi;
    ntaps = last - lo + 1;
    cur = 0; best = 0; blo = 0; bhi = 0; cur_lo = 0;
    for (int t = lo; t <= last; t++) begin
      if (good_m[t] && !silent_m[t] && !flaky_m[t]) begin
        if (cur == 0) cur_lo = t;
        cur++;
        if (cur > best) begin best = cur; blo = cur_lo; bhi = t; end
      end else cur = 0;
    end
    exp_fail = (best == 0);
    exp_sel = exp_fail ? 0 : (blo + bhi) / 2;
    if (exp_fail) begin blo = 0; bhi = 0; end

    sweep_lo_i = lo[OFS_W-1:0]; sweep_hi_i = hi[OFS_W-1:0];
    m_next_tap = lo; m_bursts = 0; m_hold = 0;
    cal_start_i = 1'b1;
    @(negedge clk);
    cal_start_i = 1'b0;
    chk(cal_busy_o == 1'b1 && cal_fail_o == 1'b0 && sel_ofs_o == '0,
        "R9", "start clears and sets busy", {cal_busy_o, cal_fail_o}, 2'b10);
    wait_n = 0;
    while (!cal_done_o && wait_n < 20000) begin
      @(negedge clk);
      wait_n++;
      if (mid_start && wait_n == 40) begin
        sweep_lo_i = 5'd30; sweep_hi_i = 5'd31;
        cal_start_i = 1'b1;
      end else if (mid_start && wait_n == 41) begin
        cal_start_i = 1'b0;
        sweep_lo_i = lo[OFS_W-1:0]; sweep_hi_i = hi[OFS_W-1:0];
      end
    end
    chk(cal_done_o == 1'b1, "R9", "done seen before watchdog", cal_done_o, 1);
    chk(m_bursts == ntaps, mid_start ? "R10" : "R2", "burst count", m_bursts, ntaps);
    chk(cal_fail_o == exp_fail, exp_fail ? "R8" : "R6", "fail flag", cal_fail_o, exp_fail);
    chk(win_lo_o == blo[OFS_W-1:0], "R6", "window low", win_lo_o, blo);
    chk(win_hi_o == bhi[OFS_W-1:0], "R6", "window high", win_hi_o, bhi);
    chk(sel_ofs_o == exp_sel[OFS_W-1:0], "R7", "chosen offset", sel_ofs_o, exp_sel);
    chk(tap_o == exp_sel[OFS_W-1:0], exp_fail ? "R8" : "R7", "tap after sweep", tap_o, exp_sel);
    h_tap = tap_o; h_sel = sel_ofs_o; h_lo = win_lo_o; h_hi = win_hi_o; h_fail = cal_fail_o;
    @(negedge clk);
    chk(cal_done_o == 1'b0, "R9", "done one cycle", cal_done_o, 0);
    m_hold = 1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(tap_o == '0 && cal_busy_o == 0 && cal_done_o == 0 && cal_fail_o == 0 &&
        sel_ofs_o == '0 && win_lo_o == '0 && win_hi_o == '0, "R1", "reset state",
        {tap_o, cal_busy_o, cal_fail_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: stray words while idle have no effect
    junk_n = 4;
    repeat (10) @(negedge clk);
    chk(cal_busy_o == 0 && cal_done_o == 0 && tap_o == '0, "R4", "idle words ignored",
        {cal_busy_o, tap_o}, 0);

    // single window in the middle
    good_m = 32'h0000_03F0; silent_m = '0; flaky_m = '0;
    run_cal(2, 12, 0);

    // R6 widest run wins, R5 silent offset, R4 one bad word, surplus words
    good_m = 32'hE000_07E6; silent_m = 32'h0000_0008; flaky_m = 32'h0000_0020;
    extra_en = 1;
    run_cal(0, 15, 0);
    extra_en = 0;

    // R6 tie keeps lowest run, R10 start during sweep
    good_m = 32'h0000_039C; silent_m = '0; flaky_m = '0;
    run_cal(0, 10, 1);

    // R8 nothing passes, R5 timeouts
    good_m = '0; silent_m = 32'h0000_0006; flaky_m = '0;
    run_cal(0, 5, 0);

    // R2 reversed range tests only the low bound
    good_m = 32'h0000_0200;
    run_cal(9, 3, 0);

    // R7 even-width window at the top of the range, floor midpoint
    good_m = 32'hFF00_0000;
    run_cal(20, 31, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule